// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block puts one short low-speed USB packet onto the D+/D- pair. A start strobe comes with a byte count of 2 to 12. The count includes the sync byte, which the block makes up itself. The block first presets the lines to idle J and then takes the bus. It sends the sync byte and after it the payload bytes, which it pulls one at a time through a fetch strobe. Each bit lasts ten clocks, is NRZI-coded and is bit-stuffed. The packet ends with an end-of-packet sequence, after which the block releases the bus and gives a done pulse.

The block also holds the device address. Software-side logic writes a new address into a pending register at any time. That value becomes the active address only during the end-of-packet of a data packet, which is any packet longer than two bytes. A two-byte handshake (sync plus PID) never commits it. CRC generation and the choice of packet content are left to the logic that feeds the bytes.

Top module: `lsusb_tx`

## Requirements
- R1: Reset (synchronous, active high) leaves oe_o, dp_o, dm_o, busy_o, done_o and fetch_o at 0 and dev_addr_o at 0, including when reset arrives in the middle of a packet.
- R2: A start_i strobe is accepted only when nbytes_i lies in 2..12. Any other count is ignored: busy_o stays 0, the bus is not driven and no fetch occurs.
- R3: In the cycle after the accepting edge, busy_o is 1, oe_o is 0 and the lines show J (dp_o=0, dm_o=1). In the cycle after that, oe_o is 1.
- R4: The first byte on the line is 0x80, and every byte goes out LSB first. Exactly nbytes_i-1 fetch_o pulses occur, each one cycle long. fetch_data_i is taken at the clock edge that ends the pulse, and the pulse comes at least one bit time before that byte's first bit.
- R5: Each bit slot lasts 10 cycles and shows J (dp=0, dm=1) or K (dp=1, dm=0). A 0 bit flips the line and a 1 bit keeps it.
- R6: After six 1 bits in a row have gone out, an extra flip (a stuffed 0) is sent and the run count restarts. This also holds across byte boundaries and after the last payload bit.
- R7: After the last slot, the block drives SE0 (dp=0, dm=0, oe=1) for 20 cycles, then J for 10 cycles. It then drops oe_o with dp_o and dm_o both 0.
- R8: done_o is a one-cycle pulse in the cycle after oe_o falls, and busy_o is 0 in that same cycle.
- R9: addr_wr_i loads addr_i into the pending address. dev_addr_o takes the pending value when SE0 starts, but only for packets with nbytes_i > 2. Two-byte packets leave it unchanged.
- R10: A start_i during a packet is ignored and the packet in flight goes out unchanged.
- R11: While busy_o is 0, oe_o, dp_o and dm_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, ten cycles per bit |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| nbytes_i | input | 4 | Packet length in bytes, sync included |
| fetch_o | output | 1 | Next-byte request pulse |
| fetch_data_i | input | 8 | Requested byte, valid at the edge ending fetch_o |
| addr_wr_i | input | 1 | Load pending device address |
| addr_i | input | 7 | Pending device address value |
| dp_o | output | 1 | D+ drive value |
| dm_o | output | 1 | D- drive value |
| oe_o | output | 1 | Bus drive enable |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dev_addr_o | output | 7 | Active device address |

## Verification
Call the edge that accepts a start E0. The preset J is due in the cycle after E0, and the first slot begins one edge later. From there, cycle index c counts cycles. Slot s takes cycles 10s to 10s+9. SE0 starts at c = 10·(8N + stuffed bits), J at +20, release at +30 and the done pulse at +31. The bench works out the stuffed-bit count and the expected slot levels from the payload alone. It samples every output on the falling edge at those exact indices and compares the whole recorded trace afterwards. It checks the address before SE0 and after the packet, and it counts fetch pulses over the whole packet.

// File: rtl/lsusb_tx_pkg.sv
package lsusb_tx_pkg;

    localparam int          BYTE_W    = 8;
    localparam int          BIDX_W    = $clog2(BYTE_W);
    localparam logic [7:0]  SYNC_BYTE = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_BIT,
        ST_SE0,
        ST_JEND,
        ST_FIN
    } tx_state_e;

    typedef enum logic [2:0] {
        LC_HOLD,
        LC_PRESET,
        LC_DATA,
        LC_STUFF,
        LC_SE0,
        LC_IDLEJ,
        LC_PARK
    } line_cmd_e;

    typedef struct packed {
        logic dp;
        logic dm;
    } line_t;

    localparam line_t LINE_J   = '{dp: 1'b0, dm: 1'b1};
    localparam line_t LINE_SE0 = '{dp: 1'b0, dm: 1'b0};

    function automatic line_t line_flip(line_t l);
        return '{dp: ~l.dp, dm: ~l.dm};
    endfunction

endpackage

// File: rtl/lsusb_bit_timer.sv
module lsusb_bit_timer #(
    parameter int BIT_CLKS = 10,
    localparam int TMR_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1
)(
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);

    logic [TMR_W-1:0] cnt_q;
    logic             last;

    assign last   = (cnt_q == TMR_W'(BIT_CLKS - 1));
    assign tick_o = run_i && last;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TMR_W'(1);
        end
    end

    assert_tmr_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TMR_W'(BIT_CLKS - 1));

    assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/lsusb_nrzi_stuffer.sv
module lsusb_nrzi_stuffer
    import lsusb_tx_pkg::*;
#(
    parameter int STUFF_RUN = 6,
    localparam int RUN_W = $clog2(STUFF_RUN + 1)
)(
    input  logic      clk,
    input  logic      rst,
    input  line_cmd_e cmd_i,
    input  logic      bit_i,
    output line_t     line_o,
    output logic      stuff_due_o
);

    line_t            line_q;
    logic [RUN_W-1:0] run_q;

    assign line_o      = line_q;
    assign stuff_due_o = (run_q == RUN_W'(STUFF_RUN));

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= LINE_SE0;
            run_q  <= '0;
        end else begin
            unique case (cmd_i)
                LC_PRESET: begin
                    line_q <= LINE_J;
                    run_q  <= '0;
                end
                LC_DATA: begin
                    if (bit_i) begin
                        run_q <= run_q + RUN_W'(1);
                    end else begin
                        line_q <= line_flip(line_q);
                        run_q  <= '0;
                    end
                end
                LC_STUFF: begin
                    line_q <= line_flip(line_q);
                    run_q  <= '0;
                end
                LC_SE0:   line_q <= LINE_SE0;
                LC_IDLEJ: line_q <= LINE_J;
                LC_PARK:  line_q <= LINE_SE0;
                default:  ;
            endcase
        end
    end

    assert_run_bound_R6: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_W'(STUFF_RUN));

    assert_no_data_when_due_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == LC_DATA) |-> !stuff_due_o);

endmodule

// File: rtl/lsusb_addr_reg.sv
module lsusb_addr_reg #(
    parameter int ADDR_W = 7
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] wdata_i,
    input  logic              commit_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] pend_q;
    logic [ADDR_W-1:0] act_q;

    assign addr_o = act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (wr_i) begin
                pend_q <= wdata_i;
            end
            if (commit_i) begin
                act_q <= pend_q;
            end
        end
    end

endmodule

// File: rtl/lsusb_tx.sv
module lsusb_tx
    import lsusb_tx_pkg::*;
#(
    parameter int BIT_CLKS     = 10,
    parameter int MIN_BYTES    = 2,
    parameter int MAX_BYTES    = 12,
    parameter int STUFF_RUN    = 6,
    parameter int EOP_SE0_BITS = 2,
    parameter int ADDR_W       = 7,
    localparam int CNT_W = $clog2(MAX_BYTES + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  nbytes_i,
    output logic              fetch_o,
    input  logic [7:0]        fetch_data_i,
    input  logic              addr_wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              dp_o,
    output logic              dm_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] dev_addr_o
);

    localparam int               EOP_W    = $clog2(EOP_SE0_BITS + 1);
    localparam logic [BIDX_W-1:0] BIT_LAST = BIDX_W'(BYTE_W - 1);

    tx_state_e          state_q;
    logic [CNT_W-1:0]   left_q;
    logic               is_data_q;
    logic [BIDX_W-1:0]  bidx_q;
    logic [7:0]         shift_q;
    logic [7:0]         next_q;
    logic               fetch_q;
    logic [EOP_W-1:0]   eop_q;
    logic               done_q;

    logic               tick;
    logic               driving;
    logic               start_ok;
    logic               stuff_due;
    logic               commit;
    line_cmd_e          cmd;
    logic               cbit;
    line_t              line;

    assign driving  = (state_q == ST_BIT) || (state_q == ST_SE0) || (state_q == ST_JEND);
    assign start_ok = (state_q == ST_IDLE) && start_i &&
                      (nbytes_i >= CNT_W'(MIN_BYTES)) && (nbytes_i <= CNT_W'(MAX_BYTES));

    lsusb_bit_timer #(.BIT_CLKS(BIT_CLKS)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .run_i  (driving),
        .tick_o (tick)
    );

    // Line command: what the encoder does at the coming edge
    always_comb begin
        cmd  = LC_HOLD;
        cbit = shift_q[0];
        unique case (state_q)
            ST_IDLE: if (start_ok) cmd = LC_PRESET;
            ST_PRE:  cmd = LC_DATA;
            ST_BIT: begin
                if (tick) begin
                    if (stuff_due) begin
                        cmd = LC_STUFF;
                    end else if (bidx_q != BIT_LAST) begin
                        cmd  = LC_DATA;
                        cbit = shift_q[1];
                    end else if (left_q == '0) begin
                        cmd = LC_SE0;
                    end else begin
                        cmd  = LC_DATA;
                        cbit = next_q[0];
                    end
                end
            end
            ST_SE0:  if (tick && eop_q == EOP_W'(EOP_SE0_BITS - 1)) cmd = LC_IDLEJ;
            ST_JEND: if (tick) cmd = LC_PARK;
            default: ;
        endcase
    end

    lsusb_nrzi_stuffer #(.STUFF_RUN(STUFF_RUN)) enc_i (
        .clk         (clk),
        .rst         (rst),
        .cmd_i       (cmd),
        .bit_i       (cbit),
        .line_o      (line),
        .stuff_due_o (stuff_due)
    );

    assign commit = (cmd == LC_SE0) && is_data_q;

    lsusb_addr_reg #(.ADDR_W(ADDR_W)) addr_i0 (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (addr_wr_i),
        .wdata_i  (addr_i),
        .commit_i (commit),
        .addr_o   (dev_addr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            left_q    <= '0;
            is_data_q <= 1'b0;
            bidx_q    <= '0;
            shift_q   <= '0;
            next_q    <= '0;
            fetch_q   <= 1'b0;
            eop_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            fetch_q <= 1'b0;
            done_q  <= 1'b0;
            if (fetch_q) begin
                next_q <= fetch_data_i;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        left_q    <= nbytes_i - CNT_W'(1);
                        is_data_q <= (nbytes_i > CNT_W'(MIN_BYTES));
                        shift_q   <= SYNC_BYTE;
                        bidx_q    <= '0;
                        state_q   <= ST_PRE;
                    end
                end
                ST_PRE: state_q <= ST_BIT;
                ST_BIT: begin
                    if (tick && !stuff_due) begin
                        if (bidx_q != BIT_LAST) begin
                            bidx_q  <= bidx_q + BIDX_W'(1);
                            shift_q <= {1'b0, shift_q[7:1]};
                            if (bidx_q == BIT_LAST - BIDX_W'(1) && left_q != '0) begin
                                fetch_q <= 1'b1;
                            end
                        end else if (left_q == '0) begin
                            state_q <= ST_SE0;
                            eop_q   <= '0;
                        end else begin
                            shift_q <= next_q;
                            bidx_q  <= '0;
                            left_q  <= left_q - CNT_W'(1);
                        end
                    end
                end
                ST_SE0: begin
                    if (tick) begin
                        if (eop_q == EOP_W'(EOP_SE0_BITS - 1)) begin
                            state_q <= ST_JEND;
                        end else begin
                            eop_q <= eop_q + EOP_W'(1);
                        end
                    end
                end
                ST_JEND: if (tick) state_q <= ST_FIN;
                ST_FIN: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign dp_o    = line.dp;
    assign dm_o    = line.dm;
    assign oe_o    = driving;
    assign busy_o  = (state_q != ST_IDLE);
    assign done_o  = done_q;
    assign fetch_o = fetch_q;

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!oe_o && !dp_o && !dm_o));

    assert_preset_j_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (!oe_o && !dp_o && dm_o));

    assert_take_bus_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |=> oe_o);

    assert_data_is_jk_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BIT) |-> (dp_o != dm_o));

    assert_fetch_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        fetch_o |=> !fetch_o);

    assert_done_after_release_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !oe_o && $past(busy_o) && !$past(oe_o)));

    assert_addr_moves_in_eop_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(dev_addr_o) |-> (oe_o && !dp_o && !dm_o));

endmodule

// File: tb/lsusb_tx_tb_top.sv
module lsusb_tx_tb_top;

    localparam int BITC = 10;
    localparam int NV   = 6;

    localparam logic [3:0]  VN [0:NV-1] = '{4'd2, 4'd4, 4'd12, 4'd3, 4'd2, 4'd5};
    localparam logic [87:0] VP [0:NV-1] = '{
        88'h0000_0000_0000_0000_0000_D2,
        88'h0000_0000_0000_0001_FFC3,
        88'hFFFF_FFFF_FFFF_FFFF_FFFF_FF,
        88'h0000_0000_0000_0000_00FC_3F,
        88'h0000_0000_0000_0000_0000_5A,
        88'h0000_0000_0000_807E_0000
    };
    localparam logic [6:0]  VA [0:NV-1] = '{7'h15, 7'h15, 7'h2A, 7'h7F, 7'h01, 7'h40};
    localparam bit          VK [0:NV-1] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [3:0] nbytes_i = '0;
    logic       fetch_o;
    logic [7:0] fetch_data_i = '0;
    logic       addr_wr_i = 1'b0;
    logic [6:0] addr_i = '0;
    logic       dp_o, dm_o, oe_o, busy_o, done_o;
    logic [6:0] dev_addr_o;

    int checks = 0;
    int failures = 0;
    int fidx = 0;
    int fcount = 0;
    logic [7:0] pay [0:10];
    logic [6:0] exp_addr = '0;

    logic [1:0] tr   [0:2047];
    logic       toe  [0:2047];
    logic       tbsy [0:2047];
    logic       tdn  [0:2047];
    logic [6:0] tad  [0:2047];
    logic [1:0] elv  [0:127];

    always #4 clk = ~clk;

    lsusb_tx dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .nbytes_i(nbytes_i),
        .fetch_o(fetch_o), .fetch_data_i(fetch_data_i),
        .addr_wr_i(addr_wr_i), .addr_i(addr_i),
        .dp_o(dp_o), .dm_o(dm_o), .oe_o(oe_o), .busy_o(busy_o),
        .done_o(done_o), .dev_addr_o(dev_addr_o)
    );

    always @(negedge clk) begin
        if (fetch_o) begin
            if (fidx < 11) fetch_data_i = pay[fidx];
            fidx++;
            fcount++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_packet(input int n, input logic [87:0] pl,
                              input logic [6:0] a, input bit poke);
        int slots, run, s, se0c, bad, total, f0;
        logic [1:0] lvl;
        logic [7:0] by;
        logic [6:0] prev_addr;
        for (int i = 0; i < 11; i++) pay[i] = pl[8*i +: 8];
        fidx = 0;
        f0 = fcount;
        @(negedge clk);
        addr_wr_i = 1'b1; addr_i = a;
        @(negedge clk);
        addr_wr_i = 1'b0;
        prev_addr = exp_addr;
        if (n > 2) exp_addr = a;
        // expected slot levels from the requirements (R4, R5, R6)
        lvl = 2'b01; run = 0; s = 0;
        for (int b = 0; b < n; b++) begin
            by = (b == 0) ? 8'h80 : pay[b-1];
            for (int i = 0; i < 8; i++) begin
                if (by[i]) run++;
                else begin lvl = ~lvl; run = 0; end
                elv[s] = lvl; s++;
                if (run == 6) begin lvl = ~lvl; run = 0; elv[s] = lvl; s++; end
            end
        end
        slots = s;
        se0c  = BITC * slots;
        total = se0c + 33;
        chk(!busy_o, "R11", "idle before start", busy_o, 0);
        start_i = 1'b1; nbytes_i = 4'(n);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !oe_o && {dp_o, dm_o} == 2'b01, "R3", "preset J, bus not taken",
            {busy_o, oe_o, dp_o, dm_o}, 4'b1001);
        for (int c = 0; c < total; c++) begin
            @(negedge clk);
            tr[c] = {dp_o, dm_o}; toe[c] = oe_o; tbsy[c] = busy_o;
            tdn[c] = done_o; tad[c] = dev_addr_o;
            if (poke && c == 50) begin start_i = 1'b1; nbytes_i = 4'd12; end
            if (poke && c == 51) start_i = 1'b0;
        end
        chk(toe[0] == 1'b1, "R3", "bus taken second cycle", toe[0], 1);
        bad = 0;
        for (int c = 0; c < se0c; c++) begin
            if (!toe[c] || tr[c] != elv[c / BITC]) bad++;
        end
        chk(bad == 0, "R5", "slot levels and 10-cycle slots", bad, 0);
        chk(bad == 0, "R6", "stuffing pattern", bad, 0);
        chk(tr[0] == 2'b10 && tr[7*BITC] == 2'b10, "R4", "sync byte 0x80 LSB first",
            {tr[0], tr[7*BITC]}, 4'b1010);
        chk(fcount - f0 == n - 1, "R4", "fetch count", fcount - f0, n - 1);
        bad = 0;
        for (int c = se0c; c < se0c + 20; c++) if (tr[c] != 2'b00 || !toe[c]) bad++;
        chk(bad == 0, "R7", "SE0 for 20 cycles", bad, 0);
        bad = 0;
        for (int c = se0c + 20; c < se0c + 30; c++) if (tr[c] != 2'b01 || !toe[c]) bad++;
        chk(bad == 0, "R7", "J for 10 cycles", bad, 0);
        chk(!toe[se0c+30] && tr[se0c+30] == 2'b00 && tbsy[se0c+30] && !tdn[se0c+30],
            "R7", "release after J", {toe[se0c+30], tr[se0c+30]}, 0);
        chk(tdn[se0c+31] && !tbsy[se0c+31] && !tdn[se0c+32], "R8", "done pulse",
            {tdn[se0c+31], tbsy[se0c+31], tdn[se0c+32]}, 3'b100);
        chk(tad[se0c-1] == prev_addr, "R9", "address unchanged before EOP",
            tad[se0c-1], prev_addr);
        chk(tad[se0c+32] == exp_addr, "R9", "address after packet",
            tad[se0c+32], exp_addr);
        if (poke) chk(tbsy[se0c+32] == 1'b0, "R10", "start during packet ignored",
                      tbsy[se0c+32], 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int f0;
        bit seen;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk({oe_o, dp_o, dm_o, busy_o, done_o, fetch_o} == 6'b0 && dev_addr_o == 7'h0,
            "R1", "reset state", {oe_o, dp_o, dm_o, busy_o, done_o, fetch_o}, 0);

        for (int v = 0; v < NV; v++) run_packet(VN[v], VP[v], VA[v], VK[v]);

        // R2: out-of-range counts ignored
        foreach (VN[k]) begin end
        for (int t = 0; t < 3; t++) begin
            f0 = fcount;
            seen = 1'b0;
            @(negedge clk);
            start_i = 1'b1;
            nbytes_i = (t == 0) ? 4'd1 : (t == 1) ? 4'd13 : 4'd0;
            @(negedge clk);
            start_i = 1'b0;
            for (int c = 0; c < 120; c++) begin
                if (busy_o || oe_o || dp_o || dm_o) seen = 1'b1;
                @(negedge clk);
            end
            chk(!seen && fcount == f0, "R2", "bad count ignored", seen, 0);
        end

        // R1: reset during a packet
        pay[0] = 8'hA5;
        @(negedge clk);
        start_i = 1'b1; nbytes_i = 4'd12;
        @(negedge clk);
        start_i = 1'b0;
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk({oe_o, dp_o, dm_o, busy_o, done_o} == 5'b0 && dev_addr_o == 7'h0,
            "R1", "reset mid-packet", {oe_o, dp_o, dm_o, busy_o, done_o}, 0);
        rst = 1'b0;
        exp_addr = '0;
        @(negedge clk);
        run_packet(2, 88'hD2, 7'h33, 1'b0);
        chk(dev_addr_o == 7'h0, "R9", "handshake keeps address after reset",
            dev_addr_o, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule